// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block brings an SDRAM device out of reset and then keeps it refreshed. After reset it keeps the clock enable low, the data masks low and the chip deselected while the supply settles. It then raises the clock enable and drives the masks high for a second, longer wait. After that wait it sends a fixed start-up sequence on the command pins: a precharge of every bank, two auto-refresh commands and a load of the mode register. Each command waits out the device's minimum spacing before the next one goes out. When the sequence ends, the ready output rises and stays high.

Once ready, a free-running interval counter raises a refresh request often enough to meet 4096 refreshes every 64 ms. A request that arrives while the user access port reports an access in progress stays pending. The block sends the refresh command in the cycle after that port goes idle. While the refresh command and its row-cycle recovery run, a busy output tells the user port to hold off. Every wait is given in nanoseconds and turned into clock counts from the clock-period parameter. Waits round up. The refresh interval rounds down.

Top module: `sdram_pwr_refresh_seq`

## Requirements
- R1: For STAB_CYC = ceil(STAB_NS / CLK_PERIOD_NS) cycles after reset (counting the reset state as cycle 0), cke_o is 0, dqm_o is all zeros and cs_n_o is 1. cke_o then rises and stays high.
- R2: While cke_o is high, dqm_o is all ones. ceil(INIT_NS / CLK_PERIOD_NS) cycles after cke_o rises, a precharge-all command appears: {cs_n,ras_n,cas_n,we_n} = 4'b0010 with addr_o bit AP_BIT = 1.
- R3: The first auto-refresh (4'b0001) comes TRP_CYC cycles after the precharge, and the second TRC_CYC cycles after the first. A gap is ceil(ns / period) and never less than 2. No two auto-refresh commands are ever closer than TRC_CYC cycles.
- R4: A mode-register load (4'b0000, addr_o = MODE_WORD) follows TRC_CYC cycles after the second auto-refresh. ready_o rises TMRD_CYC cycles after it.
- R5: In every cycle after the supply-settle hold that carries no command, the pins show NOP (4'b0111).
- R6: ref_pending_o rises floor(REFI_NS / CLK_PERIOD_NS) cycles after ready_o rises, and again every time that many further cycles pass.
- R7: When a refresh is pending and user_busy_i is low, an auto-refresh appears in the next cycle. ref_pending_o is low from that cycle on, and busy_o is high for exactly TRC_CYC cycles starting with the command.
- R8: While user_busy_i is high, no refresh is sent and ref_pending_o stays high. The refresh goes out in the cycle after user_busy_i falls.
- R9: After ready_o rises it never falls, and the only commands are NOP and auto-refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| user_busy_i | input | 1 | User access port is in the middle of an access |
| cke_o | output | 1 | SDRAM clock enable |
| dqm_o | output | DQM_W | SDRAM byte data masks |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | Address pins: precharge-all bit or mode word |
| ready_o | output | 1 | Start-up sequence complete |
| ref_pending_o | output | 1 | Refresh requested, not yet served |
| busy_o | output | 1 | Refresh command and its recovery in progress |

## Verification
On every cycle the checker enforces the following:
- the supply-settle hold keeps the masks low and the chip deselected;
- clock enable and ready never fall;
- after the hold, the masks stay high;
- once ready, only NOP and auto-refresh appear;
- refreshes are never closer together than the row-cycle count;
- a refresh never starts while the user port was busy in the previous cycle;
- busy rises only with a refresh command.

Only the bench scenarios show the exact cycle counts. These are the lengths of the two start-up waits, the precharge, refresh and mode-load spacing computed from a non-integer clock period, the refresh interval, the busy length, and a pending request being held back and then released.

// File: rtl/sdram_seq_pkg.sv
`timescale 1ns/1ps
package sdram_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_INHIBIT = 4'b1111,
    CMD_NOP     = 4'b0111,
    CMD_PREALL  = 4'b0010,
    CMD_AUTOREF = 4'b0001,
    CMD_MODESET = 4'b0000
  } sdram_cmd_t;

  typedef enum logic [3:0] {
    S_STAB, S_INIT,
    S_PRE,  S_W_PRE,
    S_AR1,  S_W_AR1,
    S_AR2,  S_W_AR2,
    S_MRS,  S_W_MRS,
    S_IDLE, S_REF, S_W_REF
  } seq_state_t;

  // wait intervals round up: never shorter than asked
  function automatic int cyc_ceil(int ns, int per);
    return (ns + per - 1) / per;
  endfunction

  // refresh interval rounds down: never longer than allowed
  function automatic int cyc_floor(int ns, int per);
    return ns / per;
  endfunction

  // command-to-command gap, at least two cycles so a wait state exists
  function automatic int cyc_gap(int ns, int per);
    int c;
    c = cyc_ceil(ns, per);
    return (c < 2) ? 2 : c;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seq_timer.sv
`timescale 1ns/1ps
module seq_timer #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= RST_VAL;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/refi_tick.sv
`timescale 1ns/1ps
module refi_tick #(
  parameter int PERIOD = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int W = (PERIOD < 2) ? 1 : $clog2(PERIOD);
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (en) begin
      if (cnt == LAST)  cnt <= '0;
      else              cnt <= cnt + 1'b1;
    end
  end

  assign tick = en && (cnt == LAST);
endmodule

// File: rtl/cmd_encode.sv
`timescale 1ns/1ps
module cmd_encode
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DQM_W  = 8,
  parameter int AP_BIT = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input  seq_state_t        st,
  output sdram_cmd_t        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              cke,
  output logic [DQM_W-1:0]  dqm
);
  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    unique case (st)
      S_STAB:              cmd = CMD_INHIBIT;
      S_PRE: begin
        cmd          = CMD_PREALL;
        addr[AP_BIT] = 1'b1;
      end
      S_AR1, S_AR2, S_REF: cmd = CMD_AUTOREF;
      S_MRS: begin
        cmd  = CMD_MODESET;
        addr = MODE_WORD;
      end
      default:             cmd = CMD_NOP;
    endcase
  end

  assign cke = (st != S_STAB);
  assign dqm = cke ? {DQM_W{1'b1}} : '0;
endmodule

// File: rtl/sdram_pwr_refresh_seq.sv
`timescale 1ns/1ps
module sdram_pwr_refresh_seq
  import sdram_seq_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int STAB_NS       = 100000,
  parameter int INIT_NS       = 200000,
  parameter int REFI_NS       = 15625,
  parameter int TRC_NS        = 70,
  parameter int TRP_NS        = 20,
  parameter int TMRD_CYC      = 2,
  parameter int ADDR_W        = 14,
  parameter int DQM_W         = 8,
  parameter int AP_BIT        = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD = ADDR_W'(14'h0032)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              user_busy_i,
  output logic              cke_o,
  output logic [DQM_W-1:0]  dqm_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ready_o,
  output logic              ref_pending_o,
  output logic              busy_o
);
  localparam int STAB_CYC = cyc_ceil(STAB_NS, CLK_PERIOD_NS);
  localparam int INIT_CYC = cyc_ceil(INIT_NS, CLK_PERIOD_NS);
  localparam int TRP_CYC  = cyc_gap(TRP_NS, CLK_PERIOD_NS);
  localparam int TRC_CYC  = cyc_gap(TRC_NS, CLK_PERIOD_NS);
  localparam int MRD_CYC  = (TMRD_CYC < 2) ? 2 : TMRD_CYC;
  localparam int REFI_CYC = cyc_floor(REFI_NS, CLK_PERIOD_NS);
  localparam int TMR_MAX  = max2(max2(STAB_CYC, INIT_CYC),
                                 max2(TRC_CYC, max2(TRP_CYC, MRD_CYC)));
  localparam int TMR_W    = $clog2(TMR_MAX + 1);

  localparam logic [TMR_W-1:0] L_STAB = TMR_W'(STAB_CYC - 1);
  localparam logic [TMR_W-1:0] L_INIT = TMR_W'(INIT_CYC - 1);
  localparam logic [TMR_W-1:0] L_TRP  = TMR_W'(TRP_CYC - 2);
  localparam logic [TMR_W-1:0] L_TRC  = TMR_W'(TRC_CYC - 2);
  localparam logic [TMR_W-1:0] L_MRD  = TMR_W'(MRD_CYC - 2);

  seq_state_t       st, st_nxt;
  logic             tmr_load, tmr_done;
  logic [TMR_W-1:0] tmr_val;
  logic             init_done;
  logic             pend_q;

  // named internal events
  logic             ref_tick;   // refresh interval elapsed
  logic             go_ref;     // pending refresh accepted this cycle
  logic             init_fin;   // start-up sequence finishing this cycle
  sdram_cmd_t       cmd;

  seq_timer #(.W(TMR_W), .RST_VAL(L_STAB)) i_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  refi_tick #(.PERIOD(REFI_CYC)) i_refi (
    .clk(clk), .rst_n(rst_n), .en(init_done), .tick(ref_tick)
  );

  always_comb begin
    st_nxt   = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    go_ref   = 1'b0;
    unique case (st)
      S_STAB:  if (tmr_done) begin st_nxt = S_INIT; tmr_load = 1'b1; tmr_val = L_INIT; end
      S_INIT:  if (tmr_done) st_nxt = S_PRE;
      S_PRE:   begin st_nxt = S_W_PRE; tmr_load = 1'b1; tmr_val = L_TRP; end
      S_W_PRE: if (tmr_done) st_nxt = S_AR1;
      S_AR1:   begin st_nxt = S_W_AR1; tmr_load = 1'b1; tmr_val = L_TRC; end
      S_W_AR1: if (tmr_done) st_nxt = S_AR2;
      S_AR2:   begin st_nxt = S_W_AR2; tmr_load = 1'b1; tmr_val = L_TRC; end
      S_W_AR2: if (tmr_done) st_nxt = S_MRS;
      S_MRS:   begin st_nxt = S_W_MRS; tmr_load = 1'b1; tmr_val = L_MRD; end
      S_W_MRS: if (tmr_done) st_nxt = S_IDLE;
      S_IDLE:  if (pend_q && !user_busy_i) begin st_nxt = S_REF; go_ref = 1'b1; end
      S_REF:   begin st_nxt = S_W_REF; tmr_load = 1'b1; tmr_val = L_TRC; end
      S_W_REF: if (tmr_done) st_nxt = S_IDLE;
      default: st_nxt = S_STAB;
    endcase
  end

  assign init_fin = (st == S_W_MRS) && tmr_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_STAB;
      init_done <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      st <= st_nxt;
      if (init_fin)      init_done <= 1'b1;
      if (ref_tick)      pend_q    <= 1'b1;   // a new tick wins over a clear
      else if (go_ref)   pend_q    <= 1'b0;
    end
  end

  cmd_encode #(
    .ADDR_W(ADDR_W), .DQM_W(DQM_W), .AP_BIT(AP_BIT), .MODE_WORD(MODE_WORD)
  ) i_enc (
    .st(st), .cmd(cmd), .addr(addr_o), .cke(cke_o), .dqm(dqm_o)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
  assign ready_o       = init_done;
  assign ref_pending_o = pend_q;
  assign busy_o        = (st == S_REF) || (st == S_W_REF);
endmodule

// File: rtl/sdram_seq_checker.sv
`timescale 1ns/1ps
module sdram_seq_checker #(
  parameter int DQM_W   = 8,
  parameter int TRC_CYC = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             user_busy_i,
  input logic             cke_o,
  input logic [DQM_W-1:0] dqm_o,
  input logic             cs_n_o,
  input logic             ras_n_o,
  input logic             cas_n_o,
  input logic             we_n_o,
  input logic             ready_o,
  input logic             ref_pending_o,
  input logic             busy_o
);
  logic [3:0] pins;
  logic       is_ref, is_nop;
  logic [7:0] gap;

  assign pins   = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
  assign is_ref = (pins == 4'b0001);
  assign is_nop = (pins == 4'b0111);

  // cycles since the last auto-refresh, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            gap <= 8'hFF;
    else if (is_ref)       gap <= 8'd1;
    else if (gap != 8'hFF) gap <= gap + 8'd1;
  end

  AST_STAB_HOLD:      assert property (@(posedge clk) disable iff (!rst_n)
                        !cke_o |-> (dqm_o == '0 && cs_n_o));                  // R1
  AST_CKE_STICKY:     assert property (@(posedge clk) disable iff (!rst_n)
                        cke_o |=> cke_o);                                      // R1
  AST_MASK_HIGH:      assert property (@(posedge clk) disable iff (!rst_n)
                        cke_o |-> (&dqm_o));                                   // R2
  AST_REF_SPACING:    assert property (@(posedge clk) disable iff (!rst_n)
                        is_ref |-> (gap >= 8'(TRC_CYC)));                      // R3
  AST_PEND_DROPS:     assert property (@(posedge clk) disable iff (!rst_n)
                        (ready_o && is_ref) |-> !ref_pending_o);               // R7
  AST_BUSY_START:     assert property (@(posedge clk) disable iff (!rst_n)
                        $rose(busy_o) |-> is_ref);                             // R7
  AST_REF_USER_IDLE:  assert property (@(posedge clk) disable iff (!rst_n)
                        (ready_o && is_ref) |-> !$past(user_busy_i));          // R8
  AST_READY_STICKY:   assert property (@(posedge clk) disable iff (!rst_n)
                        ready_o |=> ready_o);                                  // R9
  AST_READY_CMDS:     assert property (@(posedge clk) disable iff (!rst_n)
                        ready_o |-> (is_nop || is_ref));                       // R9
endmodule

bind sdram_pwr_refresh_seq sdram_seq_checker #(
  .DQM_W(DQM_W), .TRC_CYC(TRC_CYC)
) i_seq_checker (
  .clk(clk), .rst_n(rst_n), .user_busy_i(user_busy_i),
  .cke_o(cke_o), .dqm_o(dqm_o), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o),
  .cas_n_o(cas_n_o), .we_n_o(we_n_o), .ready_o(ready_o),
  .ref_pending_o(ref_pending_o), .busy_o(busy_o)
);

// File: tb/test_sdram_pwr_refresh_seq.sv
`timescale 1ns/1ps
module test_sdram_pwr_refresh_seq;
  localparam int CLK_PERIOD = 15;
  localparam int STAB_NS = 200, INIT_NS = 300, REFI_NS = 1000;
  localparam int TRC_NS = 70, TRP_NS = 20, TMRD = 2;
  localparam int ADDR_W = 14, DQM_W = 4, AP_BIT = 10;
  localparam logic [ADDR_W-1:0] MODE = 14'h0023;
  localparam int LIM = 5000;

  localparam logic [3:0] P_NOP = 4'b0111, P_PRE = 4'b0010,
                         P_REF = 4'b0001, P_MRS = 4'b0000;

  logic clk = 1'b0, rst_n = 1'b0, user_busy = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, ready, pend, busy;
  logic [DQM_W-1:0]  dqm;
  logic [ADDR_W-1:0] addr;
  logic [3:0] pins;
  assign pins = {cs_n, ras_n, cas_n, we_n};

  always #(CLK_PERIOD / 2.0) clk = ~clk;

  sdram_pwr_refresh_seq #(
    .CLK_PERIOD_NS(CLK_PERIOD), .STAB_NS(STAB_NS), .INIT_NS(INIT_NS),
    .REFI_NS(REFI_NS), .TRC_NS(TRC_NS), .TRP_NS(TRP_NS), .TMRD_CYC(TMRD),
    .ADDR_W(ADDR_W), .DQM_W(DQM_W), .AP_BIT(AP_BIT), .MODE_WORD(MODE)
  ) i_sdram_pwr_refresh_seq (
    .clk(clk), .rst_n(rst_n), .user_busy_i(user_busy), .cke_o(cke), .dqm_o(dqm),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .addr_o(addr),
    .ready_o(ready), .ref_pending_o(pend), .busy_o(busy)
  );

  // expected counts computed by repeated addition
  function automatic int up_cyc(int ns);
    int k = 0;
    while (k * CLK_PERIOD < ns) k++;
    return k;
  endfunction
  function automatic int down_cyc(int ns);
    int k = 0;
    while ((k + 1) * CLK_PERIOD <= ns) k++;
    return k;
  endfunction
  function automatic int gap_cyc(int ns);
    int k = up_cyc(ns);
    return (k < 2) ? 2 : k;
  endfunction

  int checks = 0, fails = 0, n = 0, bad = 0, bad9 = 0;
  bit rdy_seen = 0, finished = 0;
  int e_stab, e_init, e_trp, e_trc, e_refi;
  int t_cke, t_last, t_rdy, b;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    n++;
    if (rdy_seen && (!ready || (pins != P_NOP && pins != P_REF))) bad9++;
  endtask

  task automatic next_cmd();
    bad = 0;
    do begin
      step();
      if (dqm != {DQM_W{1'b1}} || !cke) bad++;
    end while (pins == P_NOP && n < LIM);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    e_stab = up_cyc(STAB_NS);
    e_init = up_cyc(INIT_NS);
    e_trp  = gap_cyc(TRP_NS);
    e_trc  = gap_cyc(TRC_NS);
    e_refi = down_cyc(REFI_NS);

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cke == 1'b0 && dqm == '0 && cs_n == 1'b1, "R1", "reset pins", cke, 0);
    chk(ready == 1'b0, "R4", "reset ready", ready, 0);
    chk(pend == 1'b0 && busy == 1'b0, "R7", "reset pending/busy", pend | busy, 0);
    rst_n = 1'b1;

    // R1: supply-settle hold
    bad = 0;
    while (cke == 1'b0 && n < LIM) begin
      if (dqm != '0 || cs_n != 1'b1) bad++;
      step();
    end
    chk(n == e_stab, "R1", "cke rise cycle", n, e_stab);
    chk(bad == 0, "R1", "masks/deselect during hold", bad, 0);
    t_cke = n;

    // R2: initialisation wait then precharge-all
    next_cmd();
    chk(pins == P_PRE, "R2", "precharge code", pins, P_PRE);
    chk(addr[AP_BIT] == 1'b1, "R2", "all-bank bit", addr[AP_BIT], 1);
    chk(n - t_cke == e_init, "R2", "init wait", n - t_cke, e_init);
    chk(bad == 0, "R5", "masks/NOP in init wait", bad, 0);
    t_last = n;

    // R3: two refreshes
    next_cmd();
    chk(pins == P_REF, "R3", "first refresh code", pins, P_REF);
    chk(n - t_last == e_trp, "R3", "precharge gap", n - t_last, e_trp);
    t_last = n;
    next_cmd();
    chk(pins == P_REF, "R3", "second refresh code", pins, P_REF);
    chk(n - t_last == e_trc, "R3", "refresh gap", n - t_last, e_trc);
    t_last = n;

    // R4: mode load then ready
    next_cmd();
    chk(pins == P_MRS, "R4", "mode load code", pins, P_MRS);
    chk(addr == MODE, "R4", "mode word", addr, MODE);
    chk(n - t_last == e_trc, "R4", "mode load gap", n - t_last, e_trc);
    t_last = n;
    bad = 0;
    do begin
      step();
      if (pins != P_NOP) bad++;
    end while (!ready && n < LIM);
    chk(n - t_last == TMRD, "R4", "ready delay", n - t_last, TMRD);
    chk(bad == 0, "R5", "NOP before ready", bad, 0);
    rdy_seen = 1;
    t_rdy = n;

    // R6/R7: first periodic refresh
    do step(); while (!pend && n < LIM);
    chk(n - t_rdy == e_refi, "R6", "first request", n - t_rdy, e_refi);
    step();
    chk(pins == P_REF, "R7", "served refresh", pins, P_REF);
    chk(pend == 1'b0, "R7", "pending cleared", pend, 0);
    b = 0;
    while (busy && n < LIM) begin b++; step(); end
    chk(b == e_trc, "R7", "busy length", b, e_trc);

    // R6: second request on the same grid
    do step(); while (!pend && n < LIM);
    chk(n - t_rdy == 2 * e_refi, "R6", "second request", n - t_rdy, 2 * e_refi);
    step();
    chk(pins == P_REF, "R7", "second served refresh", pins, P_REF);

    // R8: request held off by a busy user port
    while (n < t_rdy + 3 * e_refi - 10) step();
    user_busy = 1'b1;
    do step(); while (!pend && n < LIM);
    chk(n - t_rdy == 3 * e_refi, "R6", "request during user access", n - t_rdy, 3 * e_refi);
    bad = 0;
    for (int i = 0; i < 5; i++) begin
      step();
      if (pins == P_REF || !pend || busy) bad++;
    end
    chk(bad == 0, "R8", "refresh held while user busy", bad, 0);
    user_busy = 1'b0;
    step();
    chk(pins == P_REF, "R8", "refresh after user idle", pins, P_REF);
    chk(pend == 1'b0 && busy == 1'b1, "R8", "pending/busy after release", {pend, busy}, 1);

    chk(bad9 == 0, "R9", "ready sticky, only NOP/refresh", bad9, 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule